// File: doc/BRIEF.md
# Switching-Regulator Gate Control Core

This block is the digital control core of a single-switch current-mode power converter. It runs on the free-running oscillator clock and drives one gate-enable output for the power switch. It divides the oscillator by two to form the switching cycle. The first oscillator period of each cycle is the only window in which the gate may be on, so the duty cycle can never exceed one half. A pulse latch is set at the start of every cycle. It is cleared when either the current-mode comparator or the current-limit comparator trips, which ends the on-time for that cycle.

Two active-low control pins can override the switch. The shutdown pin forces the gate off whenever it is low. The latch-clear pin decides whether that off state is stored. If both pins are low together, an override latch sets. The gate then stays off, whatever the shutdown pin does, until the latch-clear pin goes high again. An undervoltage-good flag from the supply monitor must be high before any switching takes place. The pins and the flag each pass through a reset-initialised synchronizer before the state logic uses them. The shutdown pin and the flag also block the gate combinationally, with no clock delay.

Top module: `swreg_gate_ctrl`

## Requirements
- R1: The switching cycle lasts two oscillator clocks. The gate may be high only in the half-cycle that follows every second rising edge after reset. It is never high in two consecutive clocks. With no trips, the flag high and both pins high, the gate is high in exactly every other clock.
- R2: While `por_n` is low the gate is low. The divider, the pulse latch and the override latch clear to the non-driving state.
- R3: While `cm_trip` is high during an on-half, the gate is low in that same clock. The pulse latch is cleared at the next edge.
- R4: A trip input that is high at the rising edge starting a cycle blanks the whole on-half, even if it falls during that half. The clear dominates the set.
- R5: `ilim_trip` acts on its own and has the same effect as `cm_trip` in R3 and R4.
- R6: While `uv_ok` is low the gate is low, from the same clock on. Switching resumes no later than SYNC_STAGES edges after `uv_ok` rises.
- R7: With `shdn_n` high and `lock_clr_n` high, the block switches normally and the override latch is cleared.
- R8: With `shdn_n` high and `lock_clr_n` low, the override latch keeps its state. From a cleared latch the block switches normally; from a set latch the gate stays low.
- R9: With `shdn_n` low and `lock_clr_n` high, the gate is low from the same clock on and the off state is not stored. Switching resumes no later than SYNC_STAGES edges after `shdn_n` rises.
- R10: When the synchronized `shdn_n` and `lock_clr_n` are both low, the override latch sets and the gate stays low. This holds in either order of assertion. The gate stays low until `lock_clr_n` has been high for SYNC_STAGES+1 edges, and then switching resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| uv_ok | input | 1 | Supply-good flag from the undervoltage comparator, high when the supply is good |
| cm_trip | input | 1 | Current-mode comparator output, high ends the on-time |
| ilim_trip | input | 1 | Current-limit comparator output, high ends the on-time |
| shdn_n | input | 1 | Shutdown pin, low forces the gate off |
| lock_clr_n | input | 1 | Latch-clear pin, low lets a shutdown be stored |
| gate_en | output | 1 | Gate enable for the power switch |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and the combinational trip-kill variant. The short synchronizer makes the resume latency exact, so the bench can predict the gate value in every clock from its own count of edges since reset. Using this prediction, it sweeps all four rows of the pin table and the moves between them, including both orders of entering the latched state. It also places each trip input both at the cycle-start edge and in the middle of an on-half, and checks that the duty cycle stays at one half over long runs with no trips.

// File: rtl/swreg_gate_pkg.sv
package swreg_gate_pkg;

   // Half of the switching cycle the divider is in
   typedef enum logic {
      PH_OFF = 1'b0,
      PH_ON  = 1'b1
   } phase_e;

   // Next state of the override latch from the synchronized active-low pins.
   // Clear pin high empties the latch; clear low with shutdown low fills it;
   // clear low with shutdown high keeps it.
   function automatic logic ovr_next(input logic cur,
                                     input logic sd_n,
                                     input logic clr_n);
      logic nxt;
      if (clr_n)      nxt = 1'b0;
      else if (!sd_n) nxt = 1'b1;
      else            nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/swreg_sync.sv
module swreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("swreg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swreg_phase_div.sv
module swreg_phase_div
   import swreg_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic phase_on,
   output logic start_next
);
   phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_OFF;
      else        phase_q <= (phase_q == PH_OFF) ? PH_ON : PH_OFF;
   end

   assign phase_on   = (phase_q == PH_ON);
   assign start_next = (phase_q == PH_OFF);
endmodule

// File: rtl/swreg_pulse_latch.sv
module swreg_pulse_latch #(
   parameter int N_TRIP    = 2,
   parameter bit TRIP_COMB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_next,
   input  logic [N_TRIP-1:0] trip,
   output logic              pulse_on
);
   if (N_TRIP < 1) begin : g_bad_trip
      $error("swreg_pulse_latch: N_TRIP must be at least 1");
   end

   logic trip_any;
   logic pulse_q;

   assign trip_any = |trip;

   // Clear dominates: a trip at the cycle-start edge blanks the whole on-half
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pulse_q <= 1'b0;
      else if (trip_any) pulse_q <= 1'b0;
      else               pulse_q <= start_next;
   end

   if (TRIP_COMB) begin : g_comb_kill
      assign pulse_on = pulse_q & ~trip_any;
   end else begin : g_reg_only
      assign pulse_on = pulse_q;
   end
endmodule

// File: rtl/swreg_override_latch.sv
module swreg_override_latch
   import swreg_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sd_n_s,
   input  logic clr_n_s,
   output logic force_off
);
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= ovr_next(hold_q, sd_n_s, clr_n_s);
   end

   assign force_off = hold_q;
endmodule

// File: rtl/swreg_gate_ctrl.sv
module swreg_gate_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter bit TRIP_COMB   = 1'b1
) (
   input  logic osc_clk,
   input  logic por_n,
   input  logic uv_ok,
   input  logic cm_trip,
   input  logic ilim_trip,
   input  logic shdn_n,
   input  logic lock_clr_n,
   output logic gate_en
);
   localparam int N_TRIP = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("swreg_gate_ctrl: SYNC_STAGES must be at least 2");
   end

   logic uv_s, sd_n_s, clr_n_s;
   logic phase_on, start_next;
   logic pulse_on;
   logic ovr_force;

   swreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_uv (
      .clk(osc_clk), .rst_n(por_n), .d(uv_ok), .q(uv_s));

   swreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sd (
      .clk(osc_clk), .rst_n(por_n), .d(shdn_n), .q(sd_n_s));

   swreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
      .clk(osc_clk), .rst_n(por_n), .d(lock_clr_n), .q(clr_n_s));

   swreg_phase_div u_div (
      .clk(osc_clk), .rst_n(por_n),
      .phase_on(phase_on), .start_next(start_next));

   swreg_pulse_latch #(.N_TRIP(N_TRIP), .TRIP_COMB(TRIP_COMB)) u_pulse (
      .clk(osc_clk), .rst_n(por_n), .start_next(start_next),
      .trip({ilim_trip, cm_trip}), .pulse_on(pulse_on));

   swreg_override_latch u_ovr (
      .clk(osc_clk), .rst_n(por_n),
      .sd_n_s(sd_n_s), .clr_n_s(clr_n_s), .force_off(ovr_force));

   // Raw shdn_n and uv_ok block at once; synchronized copies cover the settle
   assign gate_en = pulse_on & phase_on & uv_ok & uv_s
                  & shdn_n & sd_n_s & ~ovr_force;
endmodule

// File: rtl/swreg_gate_ctrl_chk.sv
module swreg_gate_ctrl_chk #(
   parameter bit TRIP_COMB = 1'b1
) (
   input logic osc_clk,
   input logic por_n,
   input logic uv_ok,
   input logic cm_trip,
   input logic ilim_trip,
   input logic shdn_n,
   input logic gate_en,
   input logic ovr_force
);
   a_r1_never_two_high: assert property (@(posedge osc_clk) disable iff (!por_n)
      gate_en |=> !gate_en);

   a_r6_uv_low_blocks: assert property (@(posedge osc_clk) disable iff (!por_n)
      !uv_ok |-> !gate_en);

   a_r9_shdn_low_blocks: assert property (@(posedge osc_clk) disable iff (!por_n)
      !shdn_n |-> !gate_en);

   a_r10_latched_blocks: assert property (@(posedge osc_clk) disable iff (!por_n)
      ovr_force |-> !gate_en);

   a_r4_trip_blanks_half: assert property (@(posedge osc_clk) disable iff (!por_n)
      $past(cm_trip || ilim_trip) |-> !gate_en);

   if (TRIP_COMB) begin : g_comb_checks
      a_r3_cm_kills: assert property (@(posedge osc_clk) disable iff (!por_n)
         cm_trip |-> !gate_en);
      a_r5_ilim_kills: assert property (@(posedge osc_clk) disable iff (!por_n)
         ilim_trip |-> !gate_en);
   end
endmodule

bind swreg_gate_ctrl swreg_gate_ctrl_chk #(.TRIP_COMB(TRIP_COMB)) u_chk (
   .osc_clk(osc_clk), .por_n(por_n), .uv_ok(uv_ok), .cm_trip(cm_trip),
   .ilim_trip(ilim_trip), .shdn_n(shdn_n), .gate_en(gate_en),
   .ovr_force(ovr_force));

// File: tb/swreg_gate_ctrl_test.sv
module swreg_gate_ctrl_test;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic uv_ok = 1'b1;
   logic cm_trip = 1'b0;
   logic ilim_trip = 1'b0;
   logic shdn_n = 1'b1;
   logic lock_clr_n = 1'b1;
   logic gate_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   always @(posedge clk) if (por_n) cyc <= cyc + 1;

   swreg_gate_ctrl #(.SYNC_STAGES(SYNC), .TRIP_COMB(1'b1)) uut (
      .osc_clk(osc_clk_w), .por_n(por_n), .uv_ok(uv_ok), .cm_trip(cm_trip),
      .ilim_trip(ilim_trip), .shdn_n(shdn_n), .lock_clr_n(lock_clr_n),
      .gate_en(gate_en));

   wire osc_clk_w = clk;

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: gate_en=%0b expected %0b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Gate is on after every odd edge counted from reset release
   task automatic expect_run(input int n, input logic sw, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(gate_en, sw & cyc[0], req);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic to_parity(input logic odd);
      @(negedge clk);
      while (cyc[0] != odd) @(negedge clk);
   endtask

   task automatic trip_mid(input bit use_ilim, input string req);
      to_parity(1'b1);
      chk(gate_en, 1'b1, req);
      #2;
      if (use_ilim) ilim_trip = 1'b1; else cm_trip = 1'b1;
      #1 chk(gate_en, 1'b0, req);
      expect_run(5, 1'b0, req);
      to_parity(1'b0);
      cm_trip = 1'b0; ilim_trip = 1'b0;
      expect_run(6, 1'b1, req);
   endtask

   task automatic trip_start(input bit use_ilim, input string req);
      to_parity(1'b0);
      if (use_ilim) ilim_trip = 1'b1; else cm_trip = 1'b1;
      @(negedge clk);
      chk(gate_en, 1'b0, req);
      cm_trip = 1'b0; ilim_trip = 1'b0;
      #1 chk(gate_en, 1'b0, req);
      expect_run(6, 1'b1, req);
   endtask

   initial begin
      // R2: held in reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(gate_en, 1'b0, "R2");
      end
      por_n = 1'b1;
      // R2: synchronizer of uv_ok still settling over the first edges
      @(negedge clk);
      chk(gate_en, 1'b0, "R2");
      idle(SYNC - 1);
      // R1 and R7: free switching, exactly every other clock
      expect_run(40, 1'b1, "R1");
      expect_run(10, 1'b1, "R7");

      // R8: clear pin low from a cleared latch keeps switching
      lock_clr_n = 1'b0;
      idle(SYNC + 1);
      expect_run(12, 1'b1, "R8");
      lock_clr_n = 1'b1;
      idle(SYNC + 1);

      trip_mid(1'b0, "R3");
      trip_start(1'b0, "R4");
      trip_mid(1'b1, "R5");
      trip_start(1'b1, "R5");

      // R6: flag low blocks at once, resumes after the sync
      to_parity(1'b1);
      #2 uv_ok = 1'b0;
      #1 chk(gate_en, 1'b0, "R6");
      expect_run(10, 1'b0, "R6");
      uv_ok = 1'b1;
      idle(SYNC);
      expect_run(10, 1'b1, "R6");

      // R9: shutdown alone, not stored
      to_parity(1'b1);
      #2 shdn_n = 1'b0;
      #1 chk(gate_en, 1'b0, "R9");
      expect_run(8, 1'b0, "R9");
      shdn_n = 1'b1;
      idle(SYNC);
      expect_run(10, 1'b1, "R9");

      // R10: both low together, then shutdown released while clear held low
      shdn_n = 1'b0; lock_clr_n = 1'b0;
      expect_run(6, 1'b0, "R10");
      shdn_n = 1'b1;
      expect_run(12, 1'b0, "R8");
      lock_clr_n = 1'b1;
      idle(SYNC + 1);
      expect_run(10, 1'b1, "R10");

      // R10: shutdown first, clear second
      shdn_n = 1'b0;
      expect_run(4, 1'b0, "R10");
      lock_clr_n = 1'b0;
      expect_run(4, 1'b0, "R10");
      shdn_n = 1'b1;
      expect_run(10, 1'b0, "R10");
      lock_clr_n = 1'b1;
      idle(SYNC + 1);
      expect_run(10, 1'b1, "R10");

      // R10: clear first, shutdown second
      lock_clr_n = 1'b0;
      expect_run(4, 1'b1, "R8");
      shdn_n = 1'b0;
      expect_run(4, 1'b0, "R10");
      shdn_n = 1'b1;
      expect_run(10, 1'b0, "R10");
      lock_clr_n = 1'b1;
      idle(SYNC + 1);
      expect_run(10, 1'b1, "R10");

      // R9: shutdown low, clear pulsed low and released before shutdown: stored
      // only while both were low; with clear high again the latch empties
      shdn_n = 1'b0;
      expect_run(4, 1'b0, "R9");
      lock_clr_n = 1'b0;
      idle(SYNC + 1);
      lock_clr_n = 1'b1;
      expect_run(6, 1'b0, "R9");
      shdn_n = 1'b1;
      idle(SYNC + 1);
      expect_run(10, 1'b1, "R9");

      // R1: long duty run
      expect_run(60, 1'b1, "R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule